// File: doc/BRIEF.md
# Load/Store Byte Alignment Unit

This block sits between a 32-bit word-aligned data memory port and the register file of a load/store processor. On a load it takes the fetched memory word and produces the register value: one byte, one halfword or the whole word is picked out of the addressed lanes and zero- or sign-extended. On a store it moves register data onto the byte lanes the address names and raises a byte-enable mask, so every byte, halfword and word access is one indivisible memory operation. A mode pin chooses big- or little-endian lane numbering. Both orders and both directions go through one lane rotator.

An ordinary access whose address is not a multiple of its size is never split. It raises a misalignment flag and produces no byte enables and no register write. Unaligned data is reached only through explicit left and right operations. A load-left or load-right merges part of the memory word into the old register value. A store-left or store-right writes a partial lane set. A left/right pair assembles any unaligned word.

The data path has no storage. A request is offered with `in_valid` and the result appears with `out_valid` in the same cycle. Back-pressure passes straight through: `in_ready` equals `out_ready`. The upstream stage holds a request stable until both `out_valid` and `out_ready` are high, and the result is consumed on that cycle. `clk` and `rst_n` serve only the built-in checks.

Top module: `mem_align_unit`

## Requirements
- R1: A plain load (op_kind 0) reads byte address offset k from lane 3-k when big_endian is 1 and from lane k when it is 0, where lane i is bits 8i+7:8i. A halfword at offset 0 or 2 occupies lanes 3:2 or 1:0 (big-endian) and lanes 1:0 or 3:2 (little-endian), with the lower offset byte most significant in big-endian. A word load returns mem_rdata unchanged.
- R2: The access size is acc_size (0 byte, 1 halfword, 2 word). With ld_signed at 1, a byte or halfword load fills the upper bits with its top bit. With ld_signed at 0, it fills them with zeros.
- R3: A plain store (is_store 1) places the low byte, halfword or whole of reg_wdata on the lanes that R1 names and sets st_be to one lane, two adjacent lanes or 4'b1111. st_be is 0 for every load.
- R4: A plain halfword at an odd offset, or a plain word at a nonzero offset, sets misalign to 1, st_be to 0 and reg_we to 0. Left and right operations never set misalign.
- R5: For load-left (op_kind 1), let the addressed lane be p (3-k big-endian, k little-endian). Memory lanes p down to 0 replace register bytes 3 down to 3-p, and the lower register bytes keep reg_old.
- R6: For load-right (op_kind 2), memory lanes 3 down to p fill register bytes 3-p down to 0, and the upper register bytes keep reg_old. A load-left at offset k of one word, followed by a load-right at offset k+3 of the next word, yields the unaligned big-endian word.
- R7: Store-left writes register bytes 3..3-p to lanes p..0 with st_be covering lanes p..0. Store-right writes register bytes 3-p..0 to lanes 3..p with st_be covering lanes 3..p.
- R8: op_kind 3 behaves as op_kind 0, and acc_size 3 behaves as acc_size 2.
- R9: out_valid equals in_valid and in_ready equals out_ready in the same cycle. While in_valid is 0, reg_we, st_be and misalign are all 0.
- R10: reg_we is 1 exactly for a valid, non-misaligned load. It is 0 for every store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the built-in checks |
| rst_n | input | 1 | Active-low reset for the built-in checks |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Request accepted (equals out_ready) |
| is_store | input | 1 | 1 store, 0 load |
| op_kind | input | 2 | 0 plain, 1 left, 2 right, 3 plain |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| ld_signed | input | 1 | Sign-extend narrow loads |
| big_endian | input | 1 | 1 big-endian lane numbering |
| addr_lo | input | 2 | Byte offset within the word |
| mem_rdata | input | 32 | Fetched memory word |
| reg_old | input | 32 | Current register value for merges |
| reg_wdata | input | 32 | Register data to store |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts the result |
| ld_data | output | 32 | Load result for the register file |
| reg_we | output | 1 | Register write enable |
| st_data | output | 32 | Lane-placed store data |
| st_be | output | 4 | Store byte enables, bit i for lane i |
| misalign | output | 1 | Plain access not aligned to its size |

## Verification
The checks inside the block assume that every request field is stable across a sampling edge, and that addr_lo, op_kind and acc_size are never unknown while in_valid is high. The stimulus changes inputs only on the falling clock edge. It holds in_valid high only with fully driven fields, and it keeps in_valid low during reset. The sweep covers every offset, size, order and operation code, including the two spare codes. The checks therefore see each legal combination and never a half-driven one.

// File: rtl/align_pkg.sv
package align_pkg;
  // Lane count must be a power of two: rotation amounts wrap by truncation.
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = 4;
  localparam int unsigned WORD_W = LANE_W * LANES;
  localparam int unsigned IDX_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    OPK_PLAIN = 2'd0,
    OPK_LEFT  = 2'd1,
    OPK_RIGHT = 2'd2,
    OPK_SPARE = 2'd3
  } opk_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_SPARE = 2'd3
  } sz_e;

  typedef struct packed {
    logic [IDX_W-1:0] rot;       // rotate right by this many lanes
    logic [LANES-1:0] take;      // register bytes taken from rotated word
    logic [LANES-1:0] keep_old;  // register bytes kept from old value
    logic [LANES-1:0] be;        // store byte enables
    logic [IDX_W-1:0] top_lane;  // highest lane of a plain narrow load
    logic             misal;
  } plan_t;
endpackage

// File: rtl/align_lane_ctrl.sv
module align_lane_ctrl
  import align_pkg::*;
(
  input  logic             is_store,
  input  opk_e             opk,
  input  sz_e              sz,
  input  logic             big_endian,
  input  logic [IDX_W-1:0] addr,
  output plan_t            plan
);
  localparam logic [LANES-1:0] ALL = '1;

  logic [IDX_W:0]   nbytes;
  logic [LANES-1:0] size_mask;
  logic [IDX_W-1:0] lo;      // lowest lane of a plain access
  logic [IDX_W-1:0] p;       // lane holding the addressed byte
  logic [IDX_W-1:0] p_inv;
  logic             plain;

  always_comb begin
    unique case (sz)
      SZ_BYTE: nbytes = (IDX_W+1)'(1);
      SZ_HALF: nbytes = (IDX_W+1)'(2);
      default: nbytes = (IDX_W+1)'(LANES);
    endcase
    size_mask = ALL >> (LANES - nbytes);
    lo    = big_endian ? IDX_W'(int'(LANES) - int'(nbytes) - int'(addr)) : addr;
    p     = big_endian ? (IDX_W'(LANES - 1) - addr) : addr;
    p_inv = IDX_W'(LANES - 1) - p;
    plain = (opk == OPK_PLAIN) || (opk == OPK_SPARE);
  end

  always_comb begin
    plan          = '0;
    plan.top_lane = IDX_W'(nbytes - 1'b1);
    plan.misal    = plain && (({1'b0, addr} & (nbytes - 1'b1)) != '0);
    if (plain) begin
      if (is_store) begin
        plan.rot = IDX_W'(0) - lo;
        plan.be  = size_mask << lo;
      end else begin
        plan.rot  = lo;
        plan.take = size_mask;
      end
    end else if (opk == OPK_LEFT) begin
      if (is_store) begin
        plan.rot = p_inv;
        plan.be  = ALL >> p_inv;
      end else begin
        plan.rot      = p + 1'b1;
        plan.take     = ALL << p_inv;
        plan.keep_old = ~(ALL << p_inv);
      end
    end else begin
      if (is_store) begin
        plan.rot = IDX_W'(0) - p;
        plan.be  = ALL << p;
      end else begin
        plan.rot      = p;
        plan.take     = ALL >> p;
        plan.keep_old = ~(ALL >> p);
      end
    end
    if (plan.misal) plan.be = '0;
  end
endmodule

// File: rtl/align_rotator.sv
module align_rotator
  import align_pkg::*;
(
  input  logic [WORD_W-1:0] din,
  input  logic [IDX_W-1:0]  amt,
  output logic [WORD_W-1:0] dout
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [IDX_W-1:0] src;
    assign src = IDX_W'(g) + amt;
    assign dout[g*LANE_W +: LANE_W] = din[src*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/align_merge.sv
module align_merge
  import align_pkg::*;
(
  input  logic [WORD_W-1:0] rot_data,
  input  logic [WORD_W-1:0] reg_old,
  input  logic [LANES-1:0]  take,
  input  logic [LANES-1:0]  keep_old,
  input  logic [IDX_W-1:0]  top_lane,
  input  logic              sign_en,
  output logic [WORD_W-1:0] result
);
  logic fill_bit;
  assign fill_bit = sign_en & rot_data[top_lane*LANE_W + (LANE_W-1)];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign result[g*LANE_W +: LANE_W] =
      take[g]     ? rot_data[g*LANE_W +: LANE_W] :
      keep_old[g] ? reg_old[g*LANE_W +: LANE_W]  :
                    {LANE_W{fill_bit}};
  end
endmodule

// File: rtl/mem_align_unit.sv
module mem_align_unit
  import align_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              is_store,
  input  logic [1:0]        op_kind,
  input  logic [1:0]        acc_size,
  input  logic              ld_signed,
  input  logic              big_endian,
  input  logic [IDX_W-1:0]  addr_lo,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [WORD_W-1:0] reg_old,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] ld_data,
  output logic              reg_we,
  output logic [WORD_W-1:0] st_data,
  output logic [LANES-1:0]  st_be,
  output logic              misalign
);
  plan_t             plan;
  logic [WORD_W-1:0] rot_in;
  logic [WORD_W-1:0] rot_out;

  align_lane_ctrl u_ctrl (
    .is_store   (is_store),
    .opk        (opk_e'(op_kind)),
    .sz         (sz_e'(acc_size)),
    .big_endian (big_endian),
    .addr       (addr_lo),
    .plan       (plan)
  );

  // One rotator serves both directions; a request is either a load or a store.
  assign rot_in = is_store ? reg_wdata : mem_rdata;

  align_rotator u_rot (
    .din  (rot_in),
    .amt  (plan.rot),
    .dout (rot_out)
  );

  align_merge u_merge (
    .rot_data (rot_out),
    .reg_old  (reg_old),
    .take     (plan.take),
    .keep_old (plan.keep_old),
    .top_lane (plan.top_lane),
    .sign_en  (ld_signed),
    .result   (ld_data)
  );

  assign st_data   = rot_out;
  assign out_valid = in_valid;
  assign in_ready  = out_ready;
  assign misalign  = in_valid & plan.misal;
  assign st_be     = in_valid ? plan.be : '0;
  assign reg_we    = in_valid & ~is_store & ~plan.misal;

  // ---------------- checks ----------------
  logic [IDX_W-1:0] chk_lane;
  assign chk_lane = big_endian ? (IDX_W'(LANES - 1) - addr_lo) : addr_lo;

  a_r4_misalign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (st_be == '0) && !reg_we);

  a_r4_left_right_never_misal: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_kind == 2'd1 || op_kind == 2'd2)) |-> !misalign);

  a_r2_signed_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_store && op_kind == 2'd0 && acc_size == 2'd0 && ld_signed)
      |-> ld_data[WORD_W-1:LANE_W] == {(WORD_W-LANE_W){ld_data[LANE_W-1]}});

  a_r2_unsigned_half: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_store && op_kind == 2'd0 && acc_size == 2'd1 && !ld_signed)
      |-> ld_data[WORD_W-1:2*LANE_W] == '0);

  a_r3_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_store && op_kind == 2'd0 && acc_size == 2'd0)
      |-> $countones(st_be) == 1);

  a_r3_word_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_store && op_kind == 2'd0 && acc_size == 2'd2 && addr_lo == '0)
      |-> st_be == '1);

  a_r10_store_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_store) |-> !reg_we);

  a_r5_left_full_word: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_store && op_kind == 2'd1 && chk_lane == IDX_W'(LANES - 1))
      |-> ld_data == mem_rdata);

  a_r6_right_full_word: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_store && op_kind == 2'd2 && chk_lane == '0)
      |-> ld_data == mem_rdata);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !reg_we && (st_be == '0) && !misalign);
endmodule

// File: tb/test_mem_align_unit.sv
module test_mem_align_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready, is_store = 1'b0;
  logic [1:0]  op_kind = '0, acc_size = '0, addr_lo = '0;
  logic        ld_signed = 1'b0, big_endian = 1'b0;
  logic [31:0] mem_rdata = '0, reg_old = '0, reg_wdata = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [31:0] ld_data, st_data;
  logic        reg_we, misalign;
  logic [3:0]  st_be;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  mem_align_unit i_mem_align_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .is_store(is_store), .op_kind(op_kind), .acc_size(acc_size),
    .ld_signed(ld_signed), .big_endian(big_endian), .addr_lo(addr_lo),
    .mem_rdata(mem_rdata), .reg_old(reg_old), .reg_wdata(reg_wdata),
    .out_valid(out_valid), .out_ready(out_ready), .ld_data(ld_data),
    .reg_we(reg_we), .st_data(st_data), .st_be(st_be), .misalign(misalign)
  );

  localparam logic [31:0] T_MEM = 32'hA1B2C3F4;
  localparam logic [31:0] T_OLD = 32'h11223344;
  localparam logic [31:0] T_WD  = 32'hCAFED00D;

  typedef struct packed {
    logic        st;
    logic [1:0]  op;
    logic [1:0]  sz;
    logic        sg;
    logic        bem;
    logic [1:0]  k;
    logic [31:0] exp;
    logic [3:0]  ebe;
    logic        mis;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 2'd0, 32'h000000F4, 4'h0, 1'b0}, // R1 R2
    '{1'b0, 2'd0, 2'd0, 1'b1, 1'b0, 2'd0, 32'hFFFFFFF4, 4'h0, 1'b0}, // R2
    '{1'b0, 2'd0, 2'd0, 1'b1, 1'b1, 2'd0, 32'hFFFFFFA1, 4'h0, 1'b0}, // R1
    '{1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 2'd2, 32'h000000C3, 4'h0, 1'b0}, // R1
    '{1'b0, 2'd0, 2'd1, 1'b1, 1'b1, 2'd0, 32'hFFFFA1B2, 4'h0, 1'b0}, // R1 R2
    '{1'b0, 2'd0, 2'd1, 1'b0, 1'b0, 2'd2, 32'h0000A1B2, 4'h0, 1'b0}, // R1
    '{1'b0, 2'd0, 2'd1, 1'b1, 1'b0, 2'd0, 32'hFFFFC3F4, 4'h0, 1'b0}, // R2
    '{1'b0, 2'd0, 2'd2, 1'b1, 1'b1, 2'd0, 32'hA1B2C3F4, 4'h0, 1'b0}, // R1
    '{1'b0, 2'd1, 2'd0, 1'b0, 1'b1, 2'd1, 32'hB2C3F444, 4'h0, 1'b0}, // R5
    '{1'b0, 2'd2, 2'd0, 1'b0, 1'b1, 2'd1, 32'h1122A1B2, 4'h0, 1'b0}, // R6
    '{1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 2'd1, 32'hC3F43344, 4'h0, 1'b0}, // R5
    '{1'b0, 2'd2, 2'd0, 1'b0, 1'b0, 2'd1, 32'h11A1B2C3, 4'h0, 1'b0}, // R6
    '{1'b1, 2'd0, 2'd0, 1'b0, 1'b1, 2'd1, 32'h000D0000, 4'h4, 1'b0}, // R3
    '{1'b1, 2'd0, 2'd1, 1'b0, 1'b0, 2'd2, 32'hD00D0000, 4'hC, 1'b0}, // R3
    '{1'b1, 2'd0, 2'd2, 1'b0, 1'b1, 2'd0, 32'hCAFED00D, 4'hF, 1'b0}, // R3
    '{1'b1, 2'd1, 2'd0, 1'b0, 1'b1, 2'd1, 32'h00CAFED0, 4'h7, 1'b0}, // R7
    '{1'b1, 2'd2, 2'd0, 1'b0, 1'b1, 2'd1, 32'hD00D0000, 4'hC, 1'b0}, // R7
    '{1'b1, 2'd1, 2'd0, 1'b0, 1'b0, 2'd3, 32'hCAFED00D, 4'hF, 1'b0}, // R7
    '{1'b0, 2'd0, 2'd1, 1'b0, 1'b0, 2'd1, 32'h00000000, 4'h0, 1'b1}, // R4
    '{1'b1, 2'd0, 2'd2, 1'b0, 1'b1, 2'd2, 32'h00000000, 4'h0, 1'b1}  // R4
  };

  function automatic logic [31:0] lane_mask(logic [3:0] be);
    logic [31:0] m = '0;
    for (int i = 0; i < 4; i++) if (be[i]) m[8*i +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic int lane_of(logic bem, int off);
    return bem ? 3 - off : off;
  endfunction

  typedef struct packed {
    logic [31:0] data;
    logic [3:0]  be;
    logic        mis;
  } res_t;

  // Reference in byte-offset terms, written from the requirements.
  function automatic res_t ref_model(logic st, logic [1:0] op, logic [1:0] sz, logic sg,
                                     logic bem, logic [1:0] k, logic [31:0] mem,
                                     logic [31:0] old, logic [31:0] wd);
    res_t r;
    int kk = int'(k);
    int n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    int cnt;
    r.data = st ? 32'h0 : old;
    r.be = '0;
    r.mis = 1'b0;
    if (op == 2'd0 || op == 2'd3) begin
      r.mis = (kk % n) != 0;
      if (r.mis) return r;
      r.data = '0;
      for (int j = 0; j < n; j++) begin
        int s = bem ? n - 1 - j : j;
        int ln = lane_of(bem, kk + j);
        if (st) begin
          r.data[8*ln +: 8] = wd[8*s +: 8];
          r.be[ln] = 1'b1;
        end else r.data[8*s +: 8] = mem[8*ln +: 8];
      end
      if (!st && sg && n < 4 && r.data[8*n-1])
        for (int b = n; b < 4; b++) r.data[8*b +: 8] = 8'hFF;
    end else if (op == 2'd1) begin
      cnt = bem ? 4 - kk : kk + 1;
      for (int j = 0; j < cnt; j++) begin
        int ln = lane_of(bem, bem ? kk + j : kk - j);
        if (st) begin
          r.data[8*ln +: 8] = wd[8*(3-j) +: 8];
          r.be[ln] = 1'b1;
        end else r.data[8*(3-j) +: 8] = mem[8*ln +: 8];
      end
    end else begin
      cnt = bem ? kk + 1 : 4 - kk;
      for (int j = 0; j < cnt; j++) begin
        int ln = lane_of(bem, bem ? kk - j : kk + j);
        if (st) begin
          r.data[8*ln +: 8] = wd[8*j +: 8];
          r.be[ln] = 1'b1;
        end else r.data[8*j +: 8] = mem[8*ln +: 8];
      end
    end
    return r;
  endfunction

  task automatic drive(logic st, logic [1:0] op, logic [1:0] sz, logic sg, logic bem,
                       logic [1:0] k, logic [31:0] mem, logic [31:0] old, logic [31:0] wd);
    @(negedge clk);
    in_valid = 1'b1; is_store = st; op_kind = op; acc_size = sz; ld_signed = sg;
    big_endian = bem; addr_lo = k; mem_rdata = mem; reg_old = old; reg_wdata = wd;
    #2;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // Compare all outputs against an expectation for the driven request.
  task automatic check_result(string req, logic st, logic [31:0] exp, logic [3:0] ebe, logic mis);
    logic [31:0] got_d, exp_d;
    if (mis) begin
      got_d = 32'h0; exp_d = 32'h0;
    end else if (st) begin
      got_d = st_data & lane_mask(ebe); exp_d = exp & lane_mask(ebe);
    end else begin
      got_d = ld_data; exp_d = exp;
    end
    check(req, {got_d[27:0], st_be}, {exp_d[27:0], ebe});
    check(req, {got_d[31:28], 25'h0, reg_we, misalign, out_valid},
               {exp_d[31:28], 25'h0, !st && !mis, mis, 1'b1});
  endtask

  initial begin : watchdog
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    res_t rr;
    logic [31:0] w0, w1, acc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: idle state after reset
    #2;
    check("R9 idle", {28'h0, reg_we, misalign, out_valid, in_ready},
                     {28'h0, 1'b0, 1'b0, 1'b0, 1'b1});
    check("R9 idle be", {28'h0, st_be}, 32'h0);

    // Vector table: R1..R7
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].st, VECS[i].op, VECS[i].sz, VECS[i].sg, VECS[i].bem, VECS[i].k,
            T_MEM, T_OLD, T_WD);
      check_result($sformatf("R1-7 table %0d", i), VECS[i].st, VECS[i].exp,
                   VECS[i].ebe, VECS[i].mis);
    end

    // Full sweep against the reference: R1 R2 R3 R4 R5 R6 R7 R8 R10
    for (int pat = 0; pat < 2; pat++) begin
      for (int st = 0; st < 2; st++)
        for (int op = 0; op < 4; op++)
          for (int sz = 0; sz < 4; sz++)
            for (int sg = 0; sg < 2; sg++)
              for (int bem = 0; bem < 2; bem++)
                for (int k = 0; k < 4; k++) begin
                  logic [31:0] m = pat ? 32'h7F80017E : T_MEM;
                  logic [31:0] o = pat ? 32'h5A5AA5A5 : T_OLD;
                  logic [31:0] w = pat ? 32'h80FF7F01 : T_WD;
                  drive(st[0], op[1:0], sz[1:0], sg[0], bem[0], k[1:0], m, o, w);
                  rr = ref_model(st[0], op[1:0], sz[1:0], sg[0], bem[0], k[1:0], m, o, w);
                  check_result("R8 R10 sweep", st[0], rr.data, rr.be, rr.mis);
                end
    end

    // R6: unaligned big-endian word at offset 1 assembled by left then right
    w0 = 32'h00112233; w1 = 32'h44556677;
    drive(1'b0, 2'd1, 2'd0, 1'b0, 1'b1, 2'd1, w0, 32'hDEADBEEF, 32'h0);
    acc = ld_data;
    drive(1'b0, 2'd2, 2'd0, 1'b0, 1'b1, 2'd0, w1, acc, 32'h0);
    check("R6 pair", ld_data, 32'h11223344);

    // R9: back-pressure passes through, and idle outputs stay quiet
    drive(1'b1, 2'd0, 2'd2, 1'b0, 1'b0, 2'd0, 32'h0, 32'h0, 32'hFFFFFFFF);
    out_ready = 1'b0;
    #1;
    check("R9 ready low", {31'h0, in_ready}, 32'h0);
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b0;
    #2;
    check("R9 drop valid", {27'h0, st_be, out_valid}, 32'h0);
    check("R9 drop misal", {30'h0, reg_we, misalign}, 32'h0);
    // R4 R9: a misaligned request with in_valid low leaves misalign low
    addr_lo = 2'd1; acc_size = 2'd2; op_kind = 2'd0;
    #1;
    check("R4 R9 idle misal", {31'h0, misalign}, 32'h0);

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule